// File: doc/BRIEF.md
# Auto-Increment Parameter Memory Access Port

This block gives a host a four-word register window onto two parameter memories. The first is a 32-bit gain store of 8 channels × 62 words. The second is a 5-bit shift store of 8 channels × 14 words. Channel `c` starts at word `c × 62` in the gain store and at word `c × 14` in the shift store. Each memory has a setup word and a transfer word placed right after it. The host writes the setup word once to choose a start address, a direction and whether the address steps. It then streams words through the transfer word. Each accepted transfer moves one word and, when stepping is on, moves the internal address forward by one.

The request side is a plain strobe with no back-pressure: every request presented with `req_valid` is taken in that cycle, so a request is in effect always ready. A read request gets its answer exactly one cycle later on `rsp_valid`/`rsp_data`. There is no busy state. A read of a transfer word has a side effect, so the host must issue it once only and never speculatively. Reads in consecutive cycles each return the next word.

Top module: `param_ram_port`

## Requirements
- R1: After reset, both setup words read 0x00004000: stepping on, load off, direction read, address 0.
- R2: Word select 0 is the gain setup word, 1 is gain transfer, 2 is shift setup and 3 is shift transfer. In a setup word, bits [8:0] hold the address, bit 12 the direction (1 = write), bit 13 the address load and bit 14 stepping. A setup read returns the current internal address in [8:0] and the last written bits 12 to 14, with every other bit zero. A setup read has no side effect.
- R3: A setup write with bit 13 set loads the internal address from bits [8:0]. With bit 13 clear, the address is kept and only bits 12 to 14 change.
- R4: With stepping on and direction write, each transfer write stores the word at the current address and moves the address forward by one.
- R5: A read request is answered with `rsp_valid` high in the next cycle only. With stepping on and direction read, transfer reads in consecutive cycles return consecutive words.
- R6: With stepping off, transfer accesses leave the address unchanged, so repeated reads return the same word.
- R7: The address wraps from the last word (495 for gain, 111 for shift) to 0. A loaded address at or beyond the store size becomes 0.
- R8: A transfer write while the direction is read is ignored: the memory and the address stay unchanged. A transfer read while the direction is write returns zero and leaves the address unchanged.
- R9: The shift store keeps only bits [4:0] of written data. A shift read returns them zero-extended.
- R10: A block loaded at `c × 62` or `c × 14` reads back the words that a fill from address 0 placed at that channel's offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Word select: 0 gain setup, 1 gain transfer, 2 shift setup, 3 shift transfer |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read answer valid, one cycle after a read request |
| rsp_data | output | 32 | Read answer data, zero when not valid |

## Verification
Both stores are first filled from address 0 across their whole depth. This shows whether stepping covers every word and whether the wrap lands back on 0 instead of running past the end. A channel block is then read back with reads in consecutive cycles, which separates a correct one-cycle read path from one that repeats or skips a word. Directed cases set up stepping off, load off, a direction mismatch and an out-of-range load, each of which tells a held address apart from a moved one. A long seeded random mix of setup and transfer traffic on both stores then compares every answer with a bench model of both memories and both address counters.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int ADDR_W   = 9;
  localparam int DATA_W   = 32;
  localparam int RW_BIT   = 12;
  localparam int LOAD_BIT = 13;
  localparam int STEP_BIT = 14;

  typedef enum logic [1:0] {
    SEL_GAIN_CFG   = 2'd0,
    SEL_GAIN_XFER  = 2'd1,
    SEL_SHIFT_CFG  = 2'd2,
    SEL_SHIFT_XFER = 2'd3
  } sel_e;

  typedef struct packed {
    logic              step;
    logic              load;
    logic              wr_dir;
    logic [ADDR_W-1:0] addr;
  } cfg_t;

  function automatic logic [DATA_W-1:0] pack_cfg(cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0] = c.addr;
    w[RW_BIT]     = c.wr_dir;
    w[LOAD_BIT]   = c.load;
    w[STEP_BIT]   = c.step;
    return w;
  endfunction
endpackage

// File: rtl/apr_addr_ctrl.sv
module apr_addr_ctrl
  import apr_pkg::*;
#(
  parameter int DEPTH = 496
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  cfg_t cfg_in,
  input  logic xfer_we,
  input  logic xfer_re,
  output cfg_t state,
  output logic acc_wr,
  output logic acc_rd
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  cfg_t state_q;
  logic [ADDR_W-1:0] addr_next;

  assign acc_wr    = xfer_we && state_q.wr_dir;
  assign acc_rd    = xfer_re && !state_q.wr_dir;
  assign addr_next = (state_q.addr == LAST) ? '0 : state_q.addr + 1'b1;
  assign state     = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '{step: 1'b1, load: 1'b0, wr_dir: 1'b0, addr: '0};
    end else if (cfg_we) begin
      state_q.step   <= cfg_in.step;
      state_q.load   <= cfg_in.load;
      state_q.wr_dir <= cfg_in.wr_dir;
      if (cfg_in.load)
        state_q.addr <= (int'(cfg_in.addr) < DEPTH) ? cfg_in.addr : '0;
    end else if ((acc_wr || acc_rd) && state_q.step) begin
      state_q.addr <= addr_next;
    end
  end
endmodule

// File: rtl/apr_store.sv
module apr_store
  import apr_pkg::*;
#(
  parameter int DEPTH = 496,
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q;
  logic [IDX_W-1:0] idx;

  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end

  generate
    if (WIDTH < DATA_W) begin : g_narrow
      assign rdata = {{(DATA_W - WIDTH){1'b0}}, q};
    end else begin : g_full
      assign rdata = q[DATA_W-1:0];
    end
  endgenerate

  logic unused_hi;
  assign unused_hi = ^addr[ADDR_W-1:IDX_W];
endmodule

// File: rtl/apr_lane.sv
module apr_lane
  import apr_pkg::*;
#(
  parameter int DEPTH = 496,
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  cfg_t              cfg_in,
  input  logic              xfer_we,
  input  logic              xfer_re,
  input  logic [WIDTH-1:0]  wdata,
  output logic [DATA_W-1:0] cfg_word,
  output logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              dir_wr,
  output logic              step_on
);
  cfg_t              st;
  logic              acc_wr, acc_rd, hit_q;
  logic [DATA_W-1:0] store_q;

  apr_addr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_in),
    .xfer_we(xfer_we), .xfer_re(xfer_re), .state(st),
    .acc_wr(acc_wr), .acc_rd(acc_rd)
  );

  apr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(acc_wr), .re(acc_rd), .addr(st.addr),
    .wdata(wdata), .rdata(store_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= acc_rd;
  end

  assign rd_word  = hit_q ? store_q : '0;
  assign cfg_word = pack_cfg(st);
  assign cur_addr = st.addr;
  assign dir_wr   = st.wr_dir;
  assign step_on  = st.step;
endmodule

// File: rtl/param_ram_port.sv
module param_ram_port
  import apr_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int GAIN_WORDS  = 62,
  parameter int SHIFT_WORDS = 14,
  parameter int SHIFT_W     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_sel,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  localparam int GAIN_DEPTH  = CHANNELS * GAIN_WORDS;
  localparam int SHIFT_DEPTH = CHANNELS * SHIFT_WORDS;

  sel_e sel;
  cfg_t cfg_in;
  logic wr_req, rd_req;
  logic [DATA_W-1:0] gain_cfg_word, shift_cfg_word, gain_rd, shift_rd;
  logic [ADDR_W-1:0] gain_addr, shift_addr;
  logic gain_rw, gain_step, shift_rw, shift_step;

  assign sel    = sel_e'(req_sel);
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign cfg_in = '{step: req_wdata[STEP_BIT], load: req_wdata[LOAD_BIT],
                    wr_dir: req_wdata[RW_BIT], addr: req_wdata[ADDR_W-1:0]};

  apr_lane #(.DEPTH(GAIN_DEPTH), .WIDTH(DATA_W)) u_gain (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(wr_req && sel == SEL_GAIN_CFG), .cfg_in(cfg_in),
    .xfer_we(wr_req && sel == SEL_GAIN_XFER),
    .xfer_re(rd_req && sel == SEL_GAIN_XFER),
    .wdata(req_wdata), .cfg_word(gain_cfg_word), .rd_word(gain_rd),
    .cur_addr(gain_addr), .dir_wr(gain_rw), .step_on(gain_step)
  );

  apr_lane #(.DEPTH(SHIFT_DEPTH), .WIDTH(SHIFT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(wr_req && sel == SEL_SHIFT_CFG), .cfg_in(cfg_in),
    .xfer_we(wr_req && sel == SEL_SHIFT_XFER),
    .xfer_re(rd_req && sel == SEL_SHIFT_XFER),
    .wdata(req_wdata[SHIFT_W-1:0]), .cfg_word(shift_cfg_word), .rd_word(shift_rd),
    .cur_addr(shift_addr), .dir_wr(shift_rw), .step_on(shift_step)
  );

  logic              rsp_valid_q;
  sel_e              rsp_src_q;
  logic [DATA_W-1:0] cfg_snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_src_q   <= SEL_GAIN_CFG;
      cfg_snap_q  <= '0;
    end else begin
      rsp_valid_q <= rd_req;
      if (rd_req) begin
        rsp_src_q  <= sel;
        cfg_snap_q <= (sel == SEL_GAIN_CFG) ? gain_cfg_word : shift_cfg_word;
      end
    end
  end

  always_comb begin
    rsp_data = '0;
    if (rsp_valid_q) begin
      unique case (rsp_src_q)
        SEL_GAIN_XFER:  rsp_data = gain_rd;
        SEL_SHIFT_XFER: rsp_data = shift_rd;
        default:        rsp_data = cfg_snap_q;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
endmodule

// File: rtl/param_ram_port_chk.sv
module param_ram_port_chk
  import apr_pkg::*;
#(
  parameter int GAIN_DEPTH  = 496,
  parameter int SHIFT_DEPTH = 112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_sel,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic [ADDR_W-1:0] gain_addr,
  input logic [ADDR_W-1:0] shift_addr,
  input logic              gain_rw,
  input logic              gain_step,
  input logic              shift_rw
);
  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_no_rsp_otherwise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_gain_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gain_addr) < GAIN_DEPTH);

  p_shift_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(shift_addr) < SHIFT_DEPTH);

  p_gain_mismatch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == SEL_GAIN_XFER && !gain_rw) |=> $stable(gain_addr));

  p_shift_mismatch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_sel == SEL_SHIFT_XFER && shift_rw) |=> $stable(shift_addr));

  p_step_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel == SEL_GAIN_XFER && !gain_step) |=> $stable(gain_addr));

  p_shift_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_sel == SEL_SHIFT_XFER) |=> (rsp_data[31:5] == '0));
endmodule

bind param_ram_port param_ram_port_chk #(
  .GAIN_DEPTH(GAIN_DEPTH), .SHIFT_DEPTH(SHIFT_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_sel(req_sel), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .gain_addr(gain_addr), .shift_addr(shift_addr), .gain_rw(gain_rw),
  .gain_step(gain_step), .shift_rw(shift_rw)
);

// File: tb/param_ram_port_tb_top.sv
module param_ram_port_tb_top;
  localparam int GD = 496;
  localparam int SD = 112;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_sel = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  param_ram_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // bench model: index 0 = gain lane, 1 = shift lane
  logic [31:0] m_gain [GD];
  logic [4:0]  m_shift [SD];
  int          m_addr [2];
  bit          m_rw [2];
  bit          m_load [2];
  bit          m_step [2];

  function automatic int depth_of(int ln);
    return (ln == 0) ? GD : SD;
  endfunction

  function automatic logic [31:0] exp_cfg(int ln);
    logic [31:0] w;
    w = 32'(m_addr[ln]);
    w[12] = m_rw[ln];
    w[13] = m_load[ln];
    w[14] = m_step[ln];
    return w;
  endfunction

  function automatic int step_addr(int a, int d);
    return (a == d - 1) ? 0 : a + 1;
  endfunction

  function automatic logic [31:0] mk_cfg(bit step, bit load, bit wr, int addr);
    return 32'(addr & 9'h1FF) | (32'(wr) << 12) | (32'(load) << 13) | (32'(step) << 14);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one request; for reads, compares the answer in the following cycle
  task automatic bus(bit wr, logic [1:0] sel, logic [31:0] wd, string req);
    int ln;
    logic [31:0] exp;
    bit matched;
    ln = sel[1];
    exp = '0;
    matched = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_sel   = sel;
    req_wdata = wd;
    if (!sel[0]) begin
      if (wr) begin
        m_rw[ln] = wd[12]; m_load[ln] = wd[13]; m_step[ln] = wd[14];
        if (wd[13]) m_addr[ln] = (int'(wd[8:0]) < depth_of(ln)) ? int'(wd[8:0]) : 0;
      end else begin
        exp = exp_cfg(ln);
      end
    end else begin
      matched = (wr == m_rw[ln]);
      if (matched) begin
        if (wr) begin
          if (ln == 0) m_gain[m_addr[ln]] = wd;
          else         m_shift[m_addr[ln]] = wd[4:0];
        end else begin
          exp = (ln == 0) ? m_gain[m_addr[ln]] : {27'd0, m_shift[m_addr[ln]]};
        end
        if (m_step[ln]) m_addr[ln] = step_addr(m_addr[ln], depth_of(ln));
      end
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (!wr) begin
      check(rsp_valid === 1'b1, {req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      check(rsp_data === exp, req, rsp_data, exp);
    end
  endtask

  initial begin
    m_addr = '{0, 0}; m_rw = '{0, 0}; m_load = '{0, 0}; m_step = '{1, 1};
    void'($urandom(32'h5EED_A11C));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values, also exercises R2 setup readback
    bus(0, 2'd0, 0, "R1 gain setup reset");
    check(rsp_data === 32'h0000_4000, "R1 gain reset literal", rsp_data, 32'h4000);
    bus(0, 2'd2, 0, "R1 shift setup reset");
    check(rsp_data === 32'h0000_4000, "R1 shift reset literal", rsp_data, 32'h4000);

    // R4 fill both stores, R7 wrap back to 0, R9 truncation
    bus(1, 2'd0, mk_cfg(1, 1, 1, 0), "R4 gain setup");
    for (int i = 0; i < GD; i++) bus(1, 2'd1, $urandom, "R4 gain fill");
    bus(0, 2'd0, 0, "R7 gain wrap to zero");
    check(rsp_data[8:0] === 9'd0, "R7 gain address after full fill", 32'(rsp_data[8:0]), 0);
    bus(1, 2'd2, mk_cfg(1, 1, 1, 0), "R4 shift setup");
    for (int i = 0; i < SD; i++) bus(1, 2'd3, $urandom | 32'hFFFF_FFE0, "R9 shift fill");
    bus(0, 2'd2, 0, "R7 shift wrap to zero");

    // R5 R10 back-to-back reads of channel 3 and channel 7
    bus(1, 2'd0, mk_cfg(1, 1, 0, 3 * 62), "R10 gain ch3 load");
    for (int i = 0; i < 62; i++) bus(0, 2'd1, 0, "R5 R10 gain ch3 burst");
    bus(1, 2'd2, mk_cfg(1, 1, 0, 7 * 14), "R10 shift ch7 load");
    for (int i = 0; i < 14; i++) bus(0, 2'd3, 0, "R9 R10 shift ch7 burst");
    bus(0, 2'd2, 0, "R7 shift wrap after ch7 burst");

    // R6 stepping off: same word twice, address held
    bus(1, 2'd0, mk_cfg(0, 1, 0, 5), "R6 setup");
    bus(0, 2'd1, 0, "R6 first read");
    bus(0, 2'd1, 0, "R6 repeated read");
    bus(0, 2'd0, 0, "R6 address held");

    // R3 load bit clear keeps address, flags still change
    bus(1, 2'd0, mk_cfg(1, 0, 0, 300), "R3 setup no load");
    bus(0, 2'd0, 0, "R3 address kept");
    check(rsp_data[8:0] === 9'd5, "R3 address literal", 32'(rsp_data[8:0]), 5);

    // R8 mismatched direction
    bus(1, 2'd1, 32'hDEAD_BEEF, "R8 write in read mode");
    bus(0, 2'd1, 0, "R8 word untouched");
    bus(1, 2'd0, mk_cfg(1, 1, 1, 40), "R8 write mode");
    bus(0, 2'd1, 0, "R8 read in write mode gives zero");
    bus(0, 2'd0, 0, "R8 address unchanged");

    // R7 out-of-range load becomes zero
    bus(1, 2'd0, mk_cfg(1, 1, 0, 500), "R7 gain load 500");
    bus(0, 2'd0, 0, "R7 gain clamp");
    bus(1, 2'd2, mk_cfg(1, 1, 0, 200), "R7 shift load 200");
    bus(0, 2'd2, 0, "R7 shift clamp");
    bus(1, 2'd2, mk_cfg(1, 1, 0, 111), "R7 shift load last");
    bus(0, 2'd3, 0, "R7 shift read last");
    bus(0, 2'd3, 0, "R7 shift read after wrap");

    // random traffic, R2 R4 R5 R6 R8 R9 against the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      bit w;
      logic [31:0] d;
      s = 2'($urandom % 4);
      w = 1'($urandom % 2);
      d = $urandom;
      if (!s[0] && w) d = mk_cfg(($urandom % 4) != 0, ($urandom % 3) == 0, d[12], int'(d[8:0]));
      bus(w, s, d, "R2 random traffic");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule